// File: doc/BRIEF.md
# Serial keyboard command and event engine

This block stands in for a keyboard attached to a serial channel. The host sends command bytes on the transmit side. The engine answers some of them with fixed multi-byte response sequences. Separately, a key-event port accepts raw make and break codes. These are translated through one of two lookup tables into the codes the host expects. A one-shot prefix code selects the alternate table for the next event. The caps-lock and num-lock events pass through a small filter before translation.

Every byte produced by either path lands in a receive queue. The host drains the queue with a read strobe and sees a data-available flag. While a response sequence is being written into the queue, the engine shows `busy`. During that time it ignores both new commands and new key events.

Both 128-entry translation tables are parameters, each a packed vector holding entry `i` in bits `[8*i+7:8*i]`.

Top module: `keyserial_engine`

## Requirements
- R1: A command byte 0x01 clears the queue and then enqueues 0xFF, 0x04, 0x7F in that order.
- R2: A command byte 0x0E makes the engine ignore the next accepted command byte, whatever its value.
- R3: A command byte 0x07 or 0x0F clears the queue and then enqueues 0xFE, 0x00.
- R4: Any other command byte leaves the queue contents and the read data unchanged.
- R5: A key event with code `c` (not 0xE0 and not dropped) enqueues `PRI_MAP[c[6:0]] | (c & 0x80)`.
- R6: Key code 0xE0 enqueues nothing and arms a prefix. The next translated event uses `ALT_MAP` instead, and the prefix is then disarmed. A dropped lock event leaves the prefix armed.
- R7: Caps lock (press 0x3A, release 0xBA) and num lock (press 0x45, release 0xC5) each keep a 2-bit state starting at 0. A press flips bit 0 and a release flips bit 1. A press is dropped when the new state is 2, and a release is dropped when the new state is 3. So in a press/release/press/release cycle, only the first press and the last release are forwarded.
- R8: The queue holds `QDEPTH` (256) bytes in arrival order. A byte offered while the queue is full is discarded. While the queue is empty, `rx_avail` is 0 and `rd_data` reads 0.
- R9: `rd_data` shows the oldest byte. A cycle with `rd_strobe` high removes it, and `rx_avail` stays 1 while bytes remain.
- R10: A response's bytes enter the queue on consecutive cycles, starting one cycle after the command is accepted. `busy` is high from the cycle after acceptance until the last byte is written. Commands and key events offered while `busy` is high are ignored.
- R11: Reset empties the queue and clears the prefix, the pending command skip and both lock states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Host command byte strobe |
| cmd_byte | input | 8 | Host command byte |
| key_valid | input | 1 | Key event strobe |
| key_code | input | 8 | Raw key event, bit 7 set on release |
| rd_strobe | input | 1 | Remove the oldest queued byte |
| rd_data | output | 8 | Oldest queued byte, 0 when empty |
| rx_avail | output | 1 | Queue holds at least one byte |
| busy | output | 1 | Response sequence in progress; inputs ignored |

## Verification
A key event accepted at a clock edge is already in the queue when the next falling edge arrives, so the bench checks `rd_data` and `rx_avail` one half-cycle after each key strobe. For a command accepted at edge T, the queue is cleared and the first response byte written at T+1, the remaining bytes at T+2 and T+3, and `busy` drops after the last of them. The bench samples `busy` and the queue head at the falling edge after each of those edges. Pops are sampled before the strobe edge, and each pop result is compared with the byte the bench expected at that position.

// File: rtl/kse_pkg.sv
`timescale 1ns/1ps
// Shared constants, response kinds and helper functions for the keyboard
// command/event engine. Assumes 8-bit codes and 128-entry tables.
package kse_pkg;
    localparam int KEY_W    = 8;
    localparam int TBL_N    = 128;
    localparam int TBL_BITS = KEY_W * TBL_N;
    localparam int IDX_W    = $clog2(TBL_N);

    localparam logic [7:0] CMD_IDENT    = 8'h01;
    localparam logic [7:0] CMD_LEDS     = 8'h0E;
    localparam logic [7:0] CMD_LAYOUT_A = 8'h07;
    localparam logic [7:0] CMD_LAYOUT_B = 8'h0F;

    localparam logic [7:0] EV_PREFIX    = 8'hE0;
    localparam logic [7:0] EV_CAPS_DN   = 8'h3A;
    localparam logic [7:0] EV_CAPS_UP   = 8'hBA;
    localparam logic [7:0] EV_NUM_DN    = 8'h45;
    localparam logic [7:0] EV_NUM_UP    = 8'hC5;

    typedef enum logic [1:0] {
        RSP_NONE   = 2'd0,
        RSP_IDENT  = 2'd1,
        RSP_LAYOUT = 2'd2
    } rsp_kind_e;

    // Builds an arithmetic placeholder table: entry i = (i*mul + add) mod 128.
    function automatic logic [TBL_BITS-1:0] build_map(input int mul, input int add);
        logic [TBL_BITS-1:0] m;
        m = '0;
        for (int i = 0; i < TBL_N; i++) begin
            m[i*KEY_W +: KEY_W] = KEY_W'((i * mul + add) & (TBL_N - 1));
        end
        return m;
    endfunction

    // Number of bytes in a response of the given kind.
    function automatic logic [1:0] rsp_len(input rsp_kind_e k);
        case (k)
            RSP_IDENT:  return 2'd3;
            RSP_LAYOUT: return 2'd2;
            default:    return 2'd1;
        endcase
    endfunction

    // Byte number idx of a response of the given kind.
    function automatic logic [7:0] rsp_byte(input rsp_kind_e k, input logic [1:0] idx);
        case (k)
            RSP_IDENT: begin
                case (idx)
                    2'd0:    return 8'hFF;
                    2'd1:    return 8'h04;
                    default: return 8'h7F;
                endcase
            end
            RSP_LAYOUT: return (idx == 2'd0) ? 8'hFE : 8'h00;
            default:    return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/kse_cmd_seq.sv
`timescale 1ns/1ps
// Command sequencer: decodes host command bytes and plays out fixed response
// sequences into the receive queue, one byte per cycle, clearing the queue
// together with the first byte. Assumes cmd_go is only raised while idle.
module kse_cmd_seq
    import kse_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_go,
    input  logic [7:0] cmd_byte,
    output logic       busy,
    output logic       push,
    output logic [7:0] push_data,
    output logic       flush
);
    rsp_kind_e  kind;
    logic [1:0] step;
    logic       skip_next;

    // Decode commands, track the LED-argument skip, and step through responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind      <= RSP_NONE;
            step      <= 2'd0;
            skip_next <= 1'b0;
        end else if (kind != RSP_NONE) begin
            if (step == rsp_len(kind) - 2'd1) begin
                kind <= RSP_NONE;
                step <= 2'd0;
            end else begin
                step <= step + 2'd1;
            end
        end else if (cmd_go) begin
            if (skip_next) begin
                skip_next <= 1'b0;
            end else begin
                case (cmd_byte)
                    CMD_IDENT:                  kind <= RSP_IDENT;
                    CMD_LAYOUT_A, CMD_LAYOUT_B: kind <= RSP_LAYOUT;
                    CMD_LEDS:                   skip_next <= 1'b1;
                    default:                    ;
                endcase
            end
        end
    end

    // Drive the queue while a response is in progress.
    always_comb begin
        busy      = (kind != RSP_NONE);
        push      = busy;
        push_data = rsp_byte(kind, step);
        flush     = busy && (step == 2'd0);
    end
endmodule

// File: rtl/kse_key_xlate.sv
`timescale 1ns/1ps
// Key event translator: filters lock-key events through 2-bit state
// machines, handles the one-shot alternate-table prefix and looks up the
// translated code, keeping the release bit. Output is combinational on the
// accepted event; state updates at the accepting edge.
module kse_key_xlate
    import kse_pkg::*;
#(
    parameter logic [TBL_BITS-1:0] PRI_MAP = build_map(5, 17),
    parameter logic [TBL_BITS-1:0] ALT_MAP = build_map(3, 64)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_go,
    input  logic [7:0] ev_code,
    output logic       push,
    output logic [7:0] push_data
);
    logic [7:0] pri_tab [TBL_N];
    logic [7:0] alt_tab [TBL_N];

    // Unpack both parameter tables into indexable arrays.
    for (genvar g = 0; g < TBL_N; g++) begin : g_tab
        assign pri_tab[g] = PRI_MAP[g*KEY_W +: KEY_W];
        assign alt_tab[g] = ALT_MAP[g*KEY_W +: KEY_W];
    end

    logic       prefix;
    logic [1:0] caps_st, num_st;
    logic [1:0] caps_nx, num_nx;
    logic       drop, is_prefix;
    logic [IDX_W-1:0] idx;
    logic [7:0] entry;

    // Lock-key filtering, prefix detection and table lookup.
    always_comb begin
        caps_nx   = caps_st;
        num_nx    = num_st;
        drop      = 1'b0;
        is_prefix = (ev_code == EV_PREFIX);
        case (ev_code)
            EV_CAPS_DN: begin caps_nx = caps_st ^ 2'b01; drop = (caps_nx == 2'd2); end
            EV_CAPS_UP: begin caps_nx = caps_st ^ 2'b10; drop = (caps_nx == 2'd3); end
            EV_NUM_DN:  begin num_nx  = num_st  ^ 2'b01; drop = (num_nx  == 2'd2); end
            EV_NUM_UP:  begin num_nx  = num_st  ^ 2'b10; drop = (num_nx  == 2'd3); end
            default:    ;
        endcase
        idx       = ev_code[IDX_W-1:0];
        entry     = prefix ? alt_tab[idx] : pri_tab[idx];
        push      = ev_go && !is_prefix && !drop;
        push_data = entry | {ev_code[7], 7'b0};
    end

    // Update lock states and the prefix flag on each accepted event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prefix  <= 1'b0;
            caps_st <= 2'd0;
            num_st  <= 2'd0;
        end else if (ev_go) begin
            caps_st <= caps_nx;
            num_st  <= num_nx;
            if (is_prefix)  prefix <= 1'b1;
            else if (!drop) prefix <= 1'b0;
        end
    end
endmodule

// File: rtl/kse_rx_fifo.sv
`timescale 1ns/1ps
// Receive queue: circular byte buffer with occupancy count. A push into a
// full queue is discarded; an empty queue reads as 0. Flush empties the
// queue and may store a push in the same cycle as the first entry.
module kse_rx_fifo #(
    parameter int DEPTH = 256,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          flush,
    input  logic          pop,
    output logic [7:0]    rd_data,
    output logic          not_empty,
    output logic [CW-1:0] level
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] rptr, wptr;
    logic          full, accept, take;

    // Acceptance of pushes and pops against the current occupancy.
    always_comb begin
        full      = (level == CW'(DEPTH));
        not_empty = (level != '0);
        accept    = push && !full;
        take      = pop && not_empty;
        rd_data   = not_empty ? mem[rptr] : 8'h00;
    end

    // Storage write port.
    always_ff @(posedge clk) begin
        if (flush) begin
            if (push) mem[0] <= push_data;
        end else if (accept) begin
            mem[wptr] <= push_data;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr  <= '0;
            wptr  <= '0;
            level <= '0;
        end else if (flush) begin
            rptr  <= '0;
            wptr  <= push ? PW'(1) : '0;
            level <= push ? CW'(1) : '0;
        end else begin
            if (accept) wptr <= (wptr == LAST) ? '0 : wptr + PW'(1);
            if (take)   rptr <= (rptr == LAST) ? '0 : rptr + PW'(1);
            level <= level + CW'(accept) - CW'(take);
        end
    end
endmodule

// File: rtl/keyserial_engine.sv
`timescale 1ns/1ps
// Top of the serial keyboard command/event engine. Commands and key events
// are both ignored while a response sequence runs, so the two push sources
// into the receive queue never collide.
module keyserial_engine
    import kse_pkg::*;
#(
    parameter int QDEPTH = 256,
    parameter logic [TBL_BITS-1:0] PRI_MAP = build_map(5, 17),
    parameter logic [TBL_BITS-1:0] ALT_MAP = build_map(3, 64),
    localparam int CW = $clog2(QDEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    input  logic       key_valid,
    input  logic [7:0] key_code,
    input  logic       rd_strobe,
    output logic [7:0] rd_data,
    output logic       rx_avail,
    output logic       busy
);
    logic          cmd_go, key_go;
    logic          seq_push, seq_flush, key_push, q_push;
    logic [7:0]    seq_data, key_data, q_data;
    logic [CW-1:0] q_level;

    // Gate inputs while a response is in progress and merge push sources.
    always_comb begin
        cmd_go = cmd_valid && !busy;
        key_go = key_valid && !busy;
        q_push = seq_push || key_push;
        q_data = seq_push ? seq_data : key_data;
    end

    kse_cmd_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_go    (cmd_go),
        .cmd_byte  (cmd_byte),
        .busy      (busy),
        .push      (seq_push),
        .push_data (seq_data),
        .flush     (seq_flush)
    );

    kse_key_xlate #(
        .PRI_MAP (PRI_MAP),
        .ALT_MAP (ALT_MAP)
    ) u_xlate (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_go     (key_go),
        .ev_code   (key_code),
        .push      (key_push),
        .push_data (key_data)
    );

    kse_rx_fifo #(
        .DEPTH (QDEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (q_data),
        .flush     (seq_flush),
        .pop       (rd_strobe),
        .rd_data   (rd_data),
        .not_empty (rx_avail),
        .level     (q_level)
    );
endmodule

// File: rtl/kse_checker.sv
`timescale 1ns/1ps
// Assertion checker for keyserial_engine, attached by bind.
module kse_checker #(
    parameter int DEPTH = 256,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          rx_avail,
    input logic [7:0]    rd_data,
    input logic          rd_strobe,
    input logic          key_go,
    input logic [7:0]    key_code,
    input logic          key_push,
    input logic          flush,
    input logic [CW-1:0] level
);
    // R8: an empty queue reads as zero
    p_empty_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_avail |-> rd_data == 8'h00);

    // R8: occupancy never exceeds the depth
    p_level_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    // R8: a full queue with no pop and no clear stays full
    p_full_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (level == CW'(DEPTH) && !rd_strobe && !flush) |=> level == CW'(DEPTH));

    // R6: the prefix code never produces a byte
    p_prefix_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (key_go && key_code == 8'hE0) |-> !key_push);

    // R9: a pop with more than one byte queued leaves data available
    p_pop_keeps_avail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && level > CW'(1)) |=> rx_avail);

    // R1: when a response ends, its bytes are in the queue
    p_resp_leaves_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rx_avail);
endmodule

bind keyserial_engine kse_checker #(.DEPTH(QDEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .rx_avail  (rx_avail),
    .rd_data   (rd_data),
    .rd_strobe (rd_strobe),
    .key_go    (key_go),
    .key_code  (key_code),
    .key_push  (key_push),
    .flush     (seq_flush),
    .level     (q_level)
);

// File: tb/keyserial_engine_tb.sv
`timescale 1ns/1ps
module keyserial_engine_tb;
    localparam int DEPTH = 256;

    function automatic logic [1023:0] mk_map(input int m, input int a);
        logic [1023:0] r;
        r = '0;
        for (int i = 0; i < 128; i++) r[i*8 +: 8] = 8'((i * m + a) % 128);
        return r;
    endfunction
    function automatic logic [7:0] pri(input logic [7:0] c);
        return 8'((int'(c[6:0]) * 5 + 17) % 128) | {c[7], 7'b0};
    endfunction
    function automatic logic [7:0] alt(input logic [7:0] c);
        return 8'((int'(c[6:0]) * 3 + 64) % 128) | {c[7], 7'b0};
    endfunction

    localparam logic [1023:0] PMAP = mk_map(5, 17);
    localparam logic [1023:0] AMAP = mk_map(3, 64);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n, cmd_valid, key_valid, rd_strobe;
    logic [7:0] cmd_byte, key_code;
    logic [7:0] rd_data;
    logic       rx_avail, busy;

    keyserial_engine #(.QDEPTH(DEPTH), .PRI_MAP(PMAP), .ALT_MAP(AMAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .key_valid(key_valid), .key_code(key_code), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .rx_avail(rx_avail), .busy(busy));

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic key(input logic [7:0] c);
        key_valid = 1'b1; key_code = c;
        tick();
        key_valid = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] c);
        cmd_valid = 1'b1; cmd_byte = c;
        tick();
        cmd_valid = 1'b0;
        while (busy) tick();
    endtask

    task automatic pop_exp(input logic [7:0] e, input string req);
        chk(rx_avail && rd_data == e, req, {23'b0, rx_avail, rd_data}, {24'h1, e});
        rd_strobe = 1'b1;
        tick();
        rd_strobe = 1'b0;
    endtask

    task automatic empty_exp(input string req);
        chk(!rx_avail && rd_data == 8'h00, req, {23'b0, rx_avail, rd_data}, 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; key_valid = 1'b0; rd_strobe = 1'b0;
        cmd_byte = 8'h00; key_code = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        empty_exp("R11 reset empty");
        chk(!busy, "R11 reset busy", busy, 0);

        // R5: every press and release code outside the special ones
        for (int c = 0; c < 256; c++) begin
            if (c == 'h3A || c == 'h45 || c == 'hBA || c == 'hC5 || c == 'hE0) continue;
            key(8'(c));
            pop_exp(pri(8'(c)), "R5 primary");
        end
        empty_exp("R9 drained after sweep");

        // R6: prefix selects alternate table once
        for (int c = 0; c < 256; c++) begin
            if (c == 'h3A || c == 'h45 || c == 'hBA || c == 'hC5 || c == 'hE0) continue;
            key(8'hE0);
            empty_exp("R6 prefix silent");
            key(8'(c));
            pop_exp(alt(8'(c)), "R6 alternate");
        end
        key(8'h10);
        pop_exp(pri(8'h10), "R6 prefix cleared");

        // R7: lock filtering, two full cycles each
        for (int rep = 0; rep < 2; rep++) begin
            key(8'h3A); key(8'hBA); key(8'h3A); key(8'hBA);
            pop_exp(pri(8'h3A), "R7 caps first press");
            pop_exp(pri(8'hBA), "R7 caps second release");
            empty_exp("R7 caps drops");
            key(8'h45); key(8'hC5); key(8'h45); key(8'hC5);
            pop_exp(pri(8'h45), "R7 num first press");
            pop_exp(pri(8'hC5), "R7 num second release");
            empty_exp("R7 num drops");
        end
        // R6/R7: dropped lock event keeps prefix armed
        key(8'h3A);
        pop_exp(pri(8'h3A), "R7 caps press");
        key(8'hE0); key(8'hBA);
        empty_exp("R7 release dropped");
        key(8'h21);
        pop_exp(alt(8'h21), "R6 prefix survives drop");
        key(8'h3A); key(8'hBA);
        pop_exp(pri(8'hBA), "R7 cycle closed");

        // R1/R10: identity response, timing, keys ignored while busy
        key(8'h11); key(8'h12);
        cmd_valid = 1'b1; cmd_byte = 8'h01;
        tick();
        cmd_valid = 1'b0; key_valid = 1'b1; key_code = 8'h13;
        chk(busy, "R10 busy after accept", busy, 1);
        chk(rd_data == pri(8'h11), "R10 old data before flush", rd_data, pri(8'h11));
        tick();
        chk(busy, "R10 busy step1", busy, 1);
        chk(rx_avail && rd_data == 8'hFF, "R1 flush and first byte", rd_data, 8'hFF);
        tick();
        chk(busy, "R10 busy step2", busy, 1);
        tick();
        key_valid = 1'b0;
        chk(!busy, "R10 busy ends", busy, 0);
        pop_exp(8'hFF, "R1 byte0");
        pop_exp(8'h04, "R1 byte1");
        pop_exp(8'h7F, "R1 byte2");
        empty_exp("R10 keys ignored while busy");

        // R3: layout queries
        key(8'h14);
        cmd(8'h07);
        pop_exp(8'hFE, "R3 0x07 byte0");
        pop_exp(8'h00, "R3 0x07 byte1");
        empty_exp("R3 0x07 end");
        key(8'h15);
        cmd(8'h0F);
        pop_exp(8'hFE, "R3 0x0F byte0");
        pop_exp(8'h00, "R3 0x0F byte1");
        empty_exp("R3 0x0F end");

        // R2: LED argument skipped
        key(8'h22);
        cmd(8'h0E);
        cmd(8'h01);
        pop_exp(pri(8'h22), "R2 argument ignored");
        empty_exp("R2 no response");
        cmd(8'h0E);
        cmd(8'h0E);
        cmd(8'h07);
        pop_exp(8'hFE, "R2 skip consumed");
        pop_exp(8'h00, "R2 skip consumed b1");

        // R4: all other command values have no effect
        key(8'h11);
        for (int c = 0; c < 256; c++) begin
            if (c == 'h01 || c == 'h07 || c == 'h0E || c == 'h0F) continue;
            cmd(8'(c));
            chk(rx_avail && rd_data == pri(8'h11), "R4 no effect", rd_data, pri(8'h11));
        end
        pop_exp(pri(8'h11), "R4 contents");
        empty_exp("R4 end");

        // R8: fill to capacity, overflow discarded, ordered drain
        for (int i = 0; i < DEPTH; i++) key(8'((i & 'h1F) | (((i >> 5) & 1) << 7)));
        key(8'h05);
        for (int i = 0; i < DEPTH; i++) begin
            pop_exp(pri(8'((i & 'h1F) | (((i >> 5) & 1) << 7))), "R8 R9 ordered drain");
        end
        empty_exp("R8 overflow discarded");
        rd_strobe = 1'b1; tick(); rd_strobe = 1'b0;
        empty_exp("R8 pop on empty");

        // R11: reset clears prefix, skip, lock state and queue
        key(8'h3A);
        key(8'hE0);
        cmd(8'h0E);
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1;
        empty_exp("R11 queue cleared");
        key(8'h3A);
        pop_exp(pri(8'h3A), "R11 lock and prefix cleared");
        cmd(8'h01);
        pop_exp(8'hFF, "R11 skip cleared");
        pop_exp(8'h04, "R11 b1");
        pop_exp(8'h7F, "R11 b2");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule